// File: doc/BRIEF.md
# Masked Neighborhood Maximum Kernel

This block is the arithmetic core of a grayscale dilation filter for structuring elements that are small (up to 7 by 7) or have holes in them. Each accepted beat carries a full K by K window of unsigned pixels, arranged as K rows, together with five frame-position flags. The block returns the largest pixel among the positions that a compile-time mask selects. An external line buffer forms the windows, and border padding is also done outside the block.

The mask is a parameter, so the hardware is fixed when the block is elaborated. Each row of the window feeds its own pipelined pairwise-maximum tree, and only the selected pixels enter it. A second tree then combines the row results, and rows with no selected pixel are left out of it. Shorter rows are padded with register delay so that all row results arrive together. The frame flags pass through a delay line of the same length, so they come out on the same beat as the value they belong to.

Both stream sides use valid/ready. A result is handed over on a cycle where `out_valid` and `out_ready` are both high. A beat is taken in on a cycle where `in_valid` and `in_ready` are both high. The whole pipeline advances as one unit. It stops only when a result is waiting and the sink refuses it. Empty pipeline stages never hold it up. The source may not make `in_valid` depend on anything other than `in_ready` and its own state.

Top module: `masked_dilate_core`

## Requirements
- R1: `out_pix` is the unsigned maximum of the window pixels whose mask bit is 1. Mask bit r*K+c selects the pixel at row r, column c, which is carried in `in_win[(r*K+c)*W +: W]`. When several selected pixels share the maximum value, that value is returned.
- R2: A pixel whose mask bit is 0 has no effect on `out_pix`, whatever its value.
- R3: Let LAT be the largest ceil(log2(selected pixels in a row)) over all rows, plus ceil(log2(rows with at least one selected pixel)). With `out_ready` held high, a beat accepted at one clock edge appears on the outputs LAT cycles later. No more than LAT beats are ever held inside the block.
- R4: `out_ctl` equals the `in_ctl` of the same beat. The block carries the five flags unchanged: bit 0 line start, bit 1 line end, bit 2 frame start, bit 3 frame end, bit 4 pixel qualifier.
- R5: When LAT is above 0 and `out_valid` is high with `out_ready` low, the next cycle still shows `out_valid` high with the same `out_pix` and `out_ctl`.
- R6: `in_ready` is high whenever `out_ready` is high. When LAT is above 0, `in_ready` is low while `out_valid` is high and `out_ready` is low.
- R7: While reset is active, and in the first cycle after it, `out_valid` is low when LAT is above 0.
- R8: A mask with a single selected position makes the block a pure pass-through of that pixel, with LAT equal to 0.
- R9: Rows whose mask bits are all 0 add no latency and no comparator.
- R10: Each accepted beat produces exactly one result, and results leave in the order the beats were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A window beat is offered |
| in_ready | output | 1 | The block takes the offered beat on this cycle |
| in_win | input | K*K*W | Window pixels, row-major, pixel (r,c) at bit offset (r*K+c)*W |
| in_ctl | input | 5 | Frame-position flags of the beat |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The sink takes the result on this cycle |
| out_pix | output | W | Masked neighborhood maximum |
| out_ctl | output | 5 | Frame-position flags aligned with `out_pix` |

## Verification
The assertions assume that the handshake inputs are never unknown after reset. They also assume that, in the pass-through configuration, the source keeps its offer steady while the sink stalls, because the output is the input itself there. The stimulus raises `in_valid` only on cycles where every instance under test already shows `in_ready`, and `out_ready` changes only at the falling edge, so both assumptions hold. Four mask shapes (cross, diamond, full square, single center pixel) share one input stream. Together they cover rows of different lengths, empty rows and the zero-latency case.

// File: rtl/dilate_pkg.sv
package dilate_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MASK_BITS = 64;
  localparam int CTL_W     = 5;

  typedef logic [MASK_BITS-1:0] mask_t;

  typedef struct packed {
    logic             vld;
    logic [CTL_W-1:0] flags;
  } tag_t;

  // number of set bits among the low n bits
  function automatic int popcount_n(input mask_t m, input int n);
    int c;
    c = 0;
    for (int i = 0; i < MASK_BITS; i++)
      if (i < n && m[i]) c++;
    return c;
  endfunction

  // smallest l with 2**l >= x; 0 for x <= 1
  function automatic int ceil_log2(input int x);
    int l;
    int v;
    l = 0;
    v = 1;
    for (int i = 0; i < 32; i++)
      if (v < x) begin
        v = v * 2;
        l++;
      end
    return l;
  endfunction

  // node count of tree level l when level 0 holds c nodes
  function automatic int level_count(input int c, input int l);
    int v;
    v = c;
    for (int i = 0; i < l; i++) v = (v + 1) / 2;
    return v;
  endfunction

  // position of the k-th set bit among the low n bits
  function automatic int nth_set(input mask_t m, input int n, input int k);
    int seen;
    int pos;
    seen = 0;
    pos  = 0;
    for (int i = 0; i < MASK_BITS; i++)
      if (i < n && m[i]) begin
        if (seen == k) pos = i;
        seen++;
      end
    return pos;
  endfunction

  // mask bits of window row r, right aligned
  function automatic mask_t row_slice(input mask_t m, input int k, input int r);
    mask_t s;
    s = '0;
    for (int c = 0; c < MASK_BITS; c++)
      if (c < k && (r * k + c) < MASK_BITS) s[c] = m[r * k + c];
    return s;
  endfunction

  // bit r set when row r selects at least one pixel
  function automatic mask_t row_presence(input mask_t m, input int k);
    mask_t s;
    s = '0;
    for (int r = 0; r < MASK_BITS; r++)
      if (r < k) s[r] = (row_slice(m, k, r) != '0);
    return s;
  endfunction

  // deepest row tree
  function automatic int row_stage_max(input mask_t m, input int k);
    int d;
    int t;
    d = 0;
    for (int r = 0; r < MASK_BITS; r++)
      if (r < k) begin
        t = ceil_log2(popcount_n(row_slice(m, k, r), k));
        if (t > d) d = t;
      end
    return d;
  endfunction
endpackage

// File: rtl/dilate_delay.sv
module dilate_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic unused_dly;

  generate
    if (D == 0) begin : g_wire
      assign q          = d;
      assign unused_dly = clk ^ rst ^ en;
    end else begin : g_reg
      logic [W-1:0] sr [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < D; i++) sr[i] <= '0;
        end else if (en) begin
          sr[0] <= d;
          for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
        end
      end
      assign q          = sr[D-1];
      assign unused_dly = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/masked_max_tree.sv
module masked_max_tree
  import dilate_pkg::*;
#(
  parameter int    W   = 8,
  parameter int    N   = 5,
  parameter mask_t SEL = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [N*W-1:0] in_vec,
  output logic [W-1:0]   out_max
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT   = popcount_n(SEL, N);
  localparam int CNT_S = (CNT < 1) ? 1 : CNT;
  localparam int LAT   = ceil_log2(CNT);

  // selected inputs packed side by side; excluded taps never reach a comparator
  logic [CNT_S*W-1:0] leaf;
  logic               unused_taps;
  assign unused_taps = ^{in_vec, en, rst};

  generate
    if (CNT == 0) begin : g_none
      assign leaf = '0;
    end else begin : g_pick
      for (genvar k = 0; k < CNT; k++) begin : g_tap
        assign leaf[k*W +: W] = in_vec[nth_set(SEL, N, k)*W +: W];
      end
    end

    // one register stage per level of pairwise maxima
    for (genvar l = 1; l <= LAT; l++) begin : g_lvl
      localparam int PC = level_count(CNT, l - 1);
      localparam int NC = level_count(CNT, l);

      logic [PC*W-1:0] prev;
      logic [NC*W-1:0] cur;

      if (l == 1) begin : g_from_leaf
        assign prev = leaf;
      end else begin : g_from_lvl
        assign prev = g_lvl[l-1].cur;
      end

      // an odd last node is compared with itself, i.e. passed on
      function automatic logic [W-1:0] pair_max(input logic [PC*W-1:0] v, input int j);
        int bi;
        logic [W-1:0] a;
        logic [W-1:0] b;
        bi = (2*j + 1 < PC) ? 2*j + 1 : 2*j;
        a  = v[2*j*W +: W];
        b  = v[bi*W +: W];
        return (a >= b) ? a : b;
      endfunction

      always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else if (en)
          for (int j = 0; j < NC; j++) cur[j*W +: W] <= pair_max(prev, j);
      end
    end

    if (LAT == 0) begin : g_out_leaf
      assign out_max = leaf[W-1:0];
    end else begin : g_out_lvl
      assign out_max = g_lvl[LAT].cur;
    end
  endgenerate
endmodule

// File: rtl/masked_dilate_core.sv
module masked_dilate_core
  import dilate_pkg::*;
#(
  parameter int    W       = 8,
  parameter int    K       = 5,
  parameter mask_t SE_MASK = 64'h0000_0000_0042_7C84
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [K*K*W-1:0] in_win,
  input  logic [4:0]       in_ctl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_pix,
  output logic [4:0]       out_ctl
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam mask_t ROWS    = row_presence(SE_MASK, K);
  localparam int    ROW_LAT = row_stage_max(SE_MASK, K);
  localparam int    FIN_LAT = ceil_log2(popcount_n(ROWS, K));
  localparam int    TOT_LAT = ROW_LAT + FIN_LAT;
  localparam int    TAG_W   = $bits(tag_t);

  logic           en;
  logic           take;
  logic [K*W-1:0] row_bus;
  tag_t           tag_in;
  tag_t           tag_out;
  logic           unused_win;

  assign unused_win = ^in_win;

  // whole pipeline moves together unless a finished result is refused
  assign en = out_ready | ~tag_out.vld;

  generate
    if (TOT_LAT == 0) begin : g_comb_hs
      assign in_ready = out_ready;
      assign take     = in_valid;
    end else begin : g_pipe_hs
      assign in_ready = en;
      assign take     = in_valid & en;
    end

    for (genvar r = 0; r < K; r++) begin : g_row
      localparam mask_t RM   = row_slice(SE_MASK, K, r);
      localparam int    RCNT = popcount_n(RM, K);
      localparam int    RLAT = ceil_log2(RCNT);

      if (RCNT > 0) begin : g_live
        logic [W-1:0] rmax;
        masked_max_tree #(.W(W), .N(K), .SEL(RM)) u_row_tree (
          .clk     (clk),
          .rst     (rst),
          .en      (en),
          .in_vec  (in_win[r*K*W +: K*W]),
          .out_max (rmax)
        );
        // shorter rows wait for the deepest one
        dilate_delay #(.W(W), .D(ROW_LAT - RLAT)) u_row_align (
          .clk (clk),
          .rst (rst),
          .en  (en),
          .d   (rmax),
          .q   (row_bus[r*W +: W])
        );
      end else begin : g_dead
        assign row_bus[r*W +: W] = '0;
      end
    end
  endgenerate

  masked_max_tree #(.W(W), .N(K), .SEL(ROWS)) u_final_tree (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .in_vec  (row_bus),
    .out_max (out_pix)
  );

  assign tag_in.vld   = take;
  assign tag_in.flags = in_ctl;

  dilate_delay #(.W(TAG_W), .D(TOT_LAT)) u_tag_line (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (tag_in),
    .q   (tag_out)
  );

  assign out_valid = tag_out.vld;
  assign out_ctl   = tag_out.flags;
endmodule

// File: rtl/masked_dilate_chk.sv
module masked_dilate_chk #(
  parameter int W   = 8,
  parameter int LAT = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_pix,
  input logic [4:0]   out_ctl
);
  timeunit 1ns;
  timeprecision 1ps;

  int  occ;
  logic acc;
  logic emit;

  assign acc  = in_valid & in_ready;
  assign emit = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= 0;
    else     occ <= occ + (acc ? 1 : 0) - (emit ? 1 : 0);
  end

  // R3: never more beats inside than pipeline stages
  p_inflight_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= LAT);

  // R10: a result needs an accepted beat behind it
  p_no_phantom_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ != 0) || (LAT == 0 && in_valid));

  // R6: open sink always opens the source side
  p_in_open_r6: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  generate
    if (LAT > 0) begin : g_piped
      // R5: refused result is held
      p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_ctl));

      // R6: refused result blocks intake
      p_in_block_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

      // R7: nothing offered right after reset
      p_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
    end
  endgenerate
endmodule

bind masked_dilate_core masked_dilate_chk #(.W(W), .LAT(TOT_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .out_ctl   (out_ctl)
);

// File: tb/masked_dilate_core_bench.sv
module masked_dilate_core_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W  = 8;
  localparam int K  = 5;
  localparam int NP = K * K;
  localparam int NI = 4;

  // row r, column c -> bit r*5+c (R1)
  localparam logic [24:0] M_CROSS   = 25'h0427C84;
  localparam logic [24:0] M_DIAMOND = 25'h0477DC4;
  localparam logic [24:0] M_FULL    = 25'h1FFFFFF;
  localparam logic [24:0] M_SINGLE  = 25'h0001000;
  localparam logic [24:0] MASKS [NI] = '{M_CROSS, M_DIAMOND, M_FULL, M_SINGLE};
  // R3 formula: cross rows 1,1,5,1,1 -> 3 + ceil(log2 5)=3 -> 6; diamond and full also 6;
  // single: one pixel, one live row -> 0 (R8, R9: four empty rows add nothing)
  localparam int EXP_LAT [NI] = '{6, 6, 6, 0};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [NP*W-1:0] in_win = '0;
  logic [4:0]     in_ctl = '0;
  logic           out_ready = 1'b0;
  logic           rdy [NI];
  logic           o_v [NI];
  logic [W-1:0]   o_p [NI];
  logic [4:0]     o_c [NI];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit done_flag = 1'b0;

  // entry: kind[1:0] ctl[4:0] pix[7:0]; kind 0 random R1, 1 excluded-pixel R2, 2 latency R3
  logic [14:0] sb [NI][$];
  int          tq [NI][$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  masked_dilate_core #(.W(W), .K(K), .SE_MASK(64'h427C84)) u_masked_dilate_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[0]), .in_win(in_win),
    .in_ctl(in_ctl), .out_valid(o_v[0]), .out_ready(out_ready), .out_pix(o_p[0]), .out_ctl(o_c[0]));
  masked_dilate_core #(.W(W), .K(K), .SE_MASK(64'h477DC4)) u_masked_dilate_core_dia (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[1]), .in_win(in_win),
    .in_ctl(in_ctl), .out_valid(o_v[1]), .out_ready(out_ready), .out_pix(o_p[1]), .out_ctl(o_c[1]));
  masked_dilate_core #(.W(W), .K(K), .SE_MASK(64'h1FFFFFF)) u_masked_dilate_core_full (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[2]), .in_win(in_win),
    .in_ctl(in_ctl), .out_valid(o_v[2]), .out_ready(out_ready), .out_pix(o_p[2]), .out_ctl(o_c[2]));
  masked_dilate_core #(.W(W), .K(K), .SE_MASK(64'h1000)) u_masked_dilate_core_one (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[3]), .in_win(in_win),
    .in_ctl(in_ctl), .out_valid(o_v[3]), .out_ready(out_ready), .out_pix(o_p[3]), .out_ctl(o_c[3]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_max(input logic [24:0] m, input logic [NP*W-1:0] w);
    logic [W-1:0] best;
    best = '0;
    for (int i = 0; i < NP; i++)
      if (m[i] && w[i*W +: W] > best) best = w[i*W +: W];
    return best;
  endfunction

  function automatic logic next_ready();
    if (!bp_on) return 1'b1;
    return ($urandom % 4) != 0;
  endfunction

  function automatic bit all_ready();
    bit a;
    a = 1'b1;
    for (int i = 0; i < NI; i++) a &= rdy[i];
    return a;
  endfunction

  // driver: offer only when every instance can take the beat
  task automatic send(input logic [NP*W-1:0] w, input logic [4:0] c, input logic [1:0] kind);
    bit sent;
    sent = 1'b0;
    while (!sent) begin
      @(negedge clk);
      out_ready = next_ready();
      in_valid  = 1'b0;
      #1;
      if (all_ready()) begin
        in_valid = 1'b1;
        in_win   = w;
        in_ctl   = c;
        for (int i = 0; i < NI; i++) begin
          sb[i].push_back({kind, c, ref_max(MASKS[i], w)});
          tq[i].push_back(cyc);
        end
        sent = 1'b1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      out_ready = next_ready();
      in_valid  = 1'b0;
    end
  endtask

  function automatic bit drained();
    bit e;
    e = 1'b1;
    for (int i = 0; i < NI; i++) e &= (sb[i].size() == 0);
    return e;
  endfunction

  function automatic logic [NP*W-1:0] rand_win();
    logic [NP*W-1:0] w;
    for (int i = 0; i < NP; i++) w[i*W +: W] = W'($urandom);
    return w;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare every handed-over result with the scoreboard
  logic         prev_stall [NI];
  logic [W-1:0] prev_p [NI];
  logic [4:0]   prev_c [NI];
  initial begin
    for (int i = 0; i < NI; i++) prev_stall[i] = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (rst) begin
        // R7: no result offered during reset
        for (int i = 0; i < NI - 1; i++) chk(!o_v[i], "R7 valid in reset", o_v[i], 0);
      end else begin
        for (int i = 0; i < NI; i++) begin
          if (prev_stall[i]) begin
            chk(o_v[i] && o_p[i] == prev_p[i], "R5 held pix", o_p[i], prev_p[i]);
            chk(o_c[i] == prev_c[i], "R5 held ctl", o_c[i], prev_c[i]);
          end
          if (out_ready) chk(rdy[i], "R6 ready follows sink", rdy[i], 1);
          else if (o_v[i] && EXP_LAT[i] > 0) chk(!rdy[i], "R6 ready blocked", rdy[i], 0);
          prev_stall[i] = o_v[i] && !out_ready && EXP_LAT[i] > 0;
          prev_p[i]     = o_p[i];
          prev_c[i]     = o_c[i];
          if (o_v[i] && out_ready) begin
            if (sb[i].size() == 0) begin
              chk(1'b0, "R10 unexpected result", i, -1);
            end else begin
              logic [14:0] e;
              int t0;
              e  = sb[i].pop_front();
              t0 = tq[i].pop_front();
              if (e[14:13] == 2'd1) chk(o_p[i] == e[7:0], "R2 excluded pixels", o_p[i], e[7:0]);
              else                  chk(o_p[i] == e[7:0], "R1 masked max", o_p[i], e[7:0]);
              chk(o_c[i] == e[12:8], "R4 flags aligned", o_c[i], e[12:8]);
              if (e[14:13] == 2'd2) begin
                if (i == 3) chk(cyc - t0 == EXP_LAT[i], "R8 pass-through latency", cyc - t0, EXP_LAT[i]);
                else        chk(cyc - t0 == EXP_LAT[i], "R3 latency", cyc - t0, EXP_LAT[i]);
              end
            end
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [NP*W-1:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    for (int i = 0; i < NI - 1; i++) chk(!o_v[i], "R7 valid after reset", o_v[i], 0);

    // R3, R8, R9: single beat into an empty pipeline, sink always ready
    w = rand_win();
    send(w, 5'b10101, 2'd2);
    idle(10);

    // R2: excluded pixels saturated, selected ones low
    for (int i = 0; i < NP; i++)
      w[i*W +: W] = M_CROSS[i] ? 8'(10 + i) : 8'hFF;
    send(w, 5'b00101, 2'd1);
    for (int i = 0; i < NP; i++)
      w[i*W +: W] = M_DIAMOND[i] ? 8'd3 : 8'hFE;
    send(w, 5'b01010, 2'd1);

    // R1 corners: all zero, all max, ties
    send('0, 5'b00001, 2'd0);
    send('1, 5'b11111, 2'd0);
    for (int i = 0; i < NP; i++) w[i*W +: W] = 8'd77;
    send(w, 5'b10000, 2'd0);
    // single bright pixel walked over every position
    for (int p = 0; p < NP; p++) begin
      w = '0;
      w[p*W +: W] = 8'd200;
      send(w, 5'(p), 2'd0);
    end
    idle(10);

    // R1, R4, R5, R6, R10 under random back-pressure
    bp_on = 1'b1;
    for (int n = 0; n < 400; n++) begin
      send(rand_win(), 5'($urandom), 2'd0);
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    bp_on = 1'b0;
    idle(2);
    while (!drained()) idle(1);
    idle(4);
    finish_run();
  end
endmodule